// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a 32-bit logical address into a physical address by walking a single-level page table that lives in an external word-addressed memory. The upper bits of the logical address select a page. The lower twelve bits are a byte offset inside a 4 KB page. The page index is first compared against the table length. It is then added to the table base to address one entry word. That word is fetched and its present and permission fields are checked. The translator answers with either the physical address or a fault code.

On a successful access the entry's accessed flag is set. A write access also sets its modified flag. If either flag changes, the updated entry is stored back to the same memory word before the response is given. A faulting request never changes the table. Software places the table in memory and presents its base address and entry count on `tbl_base` and `tbl_len`. These are sampled when a request is accepted.

Top module: `page_xlate`

## Requirements
- R1: On success, `resp_paddr` is the entry's frame field (entry bits 31:12) followed by logical address bits 11:0 unchanged. For example, page 2 in frame 8 maps 0x2ABC to 0x8ABC.
- R2: The entry for page p is read from memory word `tbl_base + p`. Exactly one read is made per in-range request.
- R3: A page index greater than or equal to `tbl_len` gives fault code 1 (bounds). No memory access is made.
- R4: An in-range entry whose present flag (bit 0) is 0 gives fault code 2 (absent).
- R5: Entry bits 2:1 give the permissions: 00 read, 01 read+write, 10 read+execute, 11 all. `req_acc` is coded 00 read, 01 write, 10 execute. A disallowed access, or `req_acc` = 11, gives fault code 3 (protection).
- R6: The fault priority is bounds, then absent, then protection. On any fault `resp_fault` is 1, `resp_paddr` is 0, and no memory write is made.
- R7: A successful access sets the accessed flag (bit 4). A successful write also sets the modified flag (bit 3). The entry is written back to the same word only if this changes it; otherwise no write is made.
- R8: `req_ready` is high only while idle. Each accepted request yields exactly one single-cycle `resp_valid` pulse, with fault code 0 on success.
- R9: Once raised, `mem_req` stays high with `mem_we`, `mem_addr` and `mem_wdata` stable until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator idle and accepting |
| req_vaddr | input | 32 | Logical address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| tbl_base | input | 32 | Word address of table entry 0 |
| tbl_len | input | 21 | Number of table entries |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 1 | Request faulted |
| resp_fcode | output | 2 | 0 none, 1 bounds, 2 absent, 3 protection |
| resp_paddr | output | 32 | Physical address, 0 on fault |
| mem_req | output | 1 | Table memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Table memory word address |
| mem_wdata | output | 32 | Entry being written back |
| mem_rdata | input | 32 | Entry read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
Two decisions can fall in the same check cycle. The first is an absent entry whose permission bits also forbid the access, which must report absent rather than protection. The second is a write to an entry where both the accessed and modified flags are clear, so both flags must land in one writeback. Random entries clear the present flag a quarter of the time, with arbitrary permission bits and access kinds, and directed cases force both overlaps. A bench function derives the expected fault code and updated entry. These are compared with the response, the memory word, and the bench's counts of reads and writes.

// File: rtl/px_pkg.sv
package px_pkg;
  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  localparam logic [1:0] FC_NONE   = 2'd0;
  localparam logic [1:0] FC_BOUNDS = 2'd1;
  localparam logic [1:0] FC_ABSENT = 2'd2;
  localparam logic [1:0] FC_PROT   = 2'd3;

  localparam int PRESENT_BIT = 0;
  localparam int PERM_LO     = 1;
  localparam int MOD_BIT     = 3;
  localparam int ACC_BIT     = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CHECK, ST_WB, ST_RESP
  } px_state_e;

  // permission table: read always, write needs bit0, execute needs bit1
  function automatic logic perm_ok(input logic [1:0] perm, input logic [1:0] acc);
    case (acc)
      ACC_RD:  return 1'b1;
      ACC_WR:  return perm[0];
      ACC_EX:  return perm[1];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/px_split.sv
module px_split #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  localparam int VPN_W = VA_W - OFF_W
) (
  input  logic [VA_W-1:0]  vaddr,
  output logic [VPN_W-1:0] vpn,
  output logic [OFF_W-1:0] off
);
  assign vpn = vaddr[VA_W-1:OFF_W];
  assign off = vaddr[OFF_W-1:0];
endmodule

// File: rtl/px_check.sv
module px_check import px_pkg::*; #(
  parameter int DW      = 32,
  parameter int FRAME_W = 20,
  parameter int OFF_W   = 12,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic [DW-1:0]    pte,
  input  logic [1:0]       acc,
  input  logic [OFF_W-1:0] off,
  output logic [1:0]       fcode,
  output logic [PA_W-1:0]  paddr,
  output logic [DW-1:0]    new_pte,
  output logic             wb_need
);
  function automatic logic [DW-1:0] mark(input logic [DW-1:0] e, input logic [1:0] a);
    logic [DW-1:0] r;
    r = e;
    r[ACC_BIT] = 1'b1;
    if (a == ACC_WR) r[MOD_BIT] = 1'b1;
    return r;
  endfunction

  always_comb begin
    if (!pte[PRESENT_BIT])                           fcode = FC_ABSENT;
    else if (!perm_ok(pte[PERM_LO +: 2], acc))       fcode = FC_PROT;
    else                                             fcode = FC_NONE;
  end

  assign paddr   = (fcode == FC_NONE) ? {pte[DW-1 -: FRAME_W], off} : '0;
  assign new_pte = mark(pte, acc);
  assign wb_need = (fcode == FC_NONE) && (new_pte != pte);
endmodule

// File: rtl/px_ctrl.sv
module px_ctrl import px_pkg::*; #(
  parameter int VPN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int DW     = 32,
  parameter int MEM_AW = 32,
  parameter int PA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  input  logic [MEM_AW-1:0] tbl_base,
  input  logic [VPN_W:0]    tbl_len,
  output logic [DW-1:0]     chk_pte,
  output logic [1:0]        chk_acc,
  output logic [OFF_W-1:0]  chk_off,
  input  logic [1:0]        chk_fcode,
  input  logic [PA_W-1:0]   chk_paddr,
  input  logic [DW-1:0]     chk_new_pte,
  input  logic              chk_wb,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [1:0]        resp_fcode,
  output logic [PA_W-1:0]   resp_paddr
);
  px_state_e state;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        acc_q;
  logic [MEM_AW-1:0] base_q;
  logic [DW-1:0]     pte_q;
  logic [1:0]        fcode_q;
  logic [PA_W-1:0]   paddr_q;

  // named events for the assertions
  logic accept, bounds_hit, check_fault;
  assign accept      = (state == ST_IDLE) && req_valid;
  assign bounds_hit  = accept && ({1'b0, req_vpn} >= tbl_len);
  assign check_fault = (state == ST_CHECK) && (chk_fcode != FC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      vpn_q   <= '0;
      off_q   <= '0;
      acc_q   <= '0;
      base_q  <= '0;
      pte_q   <= '0;
      fcode_q <= FC_NONE;
      paddr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          vpn_q  <= req_vpn;
          off_q  <= req_off;
          acc_q  <= req_acc;
          base_q <= tbl_base;
          if (bounds_hit) begin
            fcode_q <= FC_BOUNDS;
            paddr_q <= '0;
            state   <= ST_RESP;
          end else begin
            state <= ST_READ;
          end
        end
        ST_READ: if (mem_ack) begin
          pte_q <= mem_rdata;
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          fcode_q <= chk_fcode;
          paddr_q <= chk_paddr;
          state   <= chk_wb ? ST_WB : ST_RESP;
        end
        ST_WB: if (mem_ack) state <= ST_RESP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign mem_req    = (state == ST_READ) || (state == ST_WB);
  assign mem_we     = (state == ST_WB);
  assign mem_addr   = base_q + {{(MEM_AW-VPN_W){1'b0}}, vpn_q};
  assign mem_wdata  = chk_new_pte;
  assign chk_pte    = pte_q;
  assign chk_acc    = acc_q;
  assign chk_off    = off_q;
  assign resp_valid = (state == ST_RESP);
  assign resp_fault = (fcode_q != FC_NONE);
  assign resp_fcode = fcode_q;
  assign resp_paddr = paddr_q;

  assert_bounds_noread_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bounds_hit |=> (resp_valid && !mem_req));
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
  assert_fault_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    check_fault |=> (resp_valid && !mem_req));
  assert_wb_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[ACC_BIT] && (mem_wdata != pte_q)));
  assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready));
  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !resp_valid));
  assert_fault_nopaddr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_paddr == '0));
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  parameter int DW      = 32,
  parameter int MEM_AW  = 32,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic [MEM_AW-1:0] tbl_base,
  input  logic [VPN_W:0]    tbl_len,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [1:0]        resp_fcode,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack
);
  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;
  logic [DW-1:0]    chk_pte, chk_new_pte;
  logic [1:0]       chk_acc, chk_fcode;
  logic [OFF_W-1:0] chk_off;
  logic [PA_W-1:0]  chk_paddr;
  logic             chk_wb;

  px_split #(.VA_W(VA_W), .OFF_W(OFF_W)) u_split (
    .vaddr(req_vaddr), .vpn(vpn), .off(off));

  px_check #(.DW(DW), .FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_check (
    .pte(chk_pte), .acc(chk_acc), .off(chk_off), .fcode(chk_fcode),
    .paddr(chk_paddr), .new_pte(chk_new_pte), .wb_need(chk_wb));

  px_ctrl #(.VPN_W(VPN_W), .OFF_W(OFF_W), .DW(DW), .MEM_AW(MEM_AW), .PA_W(PA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(vpn), .req_off(off), .req_acc(req_acc), .tbl_base(tbl_base),
    .tbl_len(tbl_len), .chk_pte(chk_pte), .chk_acc(chk_acc), .chk_off(chk_off),
    .chk_fcode(chk_fcode), .chk_paddr(chk_paddr), .chk_new_pte(chk_new_pte),
    .chk_wb(chk_wb), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_fcode(resp_fcode),
    .resp_paddr(resp_paddr));
endmodule

// File: tb/tb_page_xlate.sv
`timescale 1ns/1ps
module tb_page_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [31:0] tbl_base = '0;
  logic [20:0] tbl_len = '0;
  logic        resp_valid, resp_fault;
  logic [1:0]  resp_fcode;
  logic [31:0] resp_paddr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  page_xlate dut (.*);

  // table memory model with a one-cycle acknowledge
  logic [31:0] mem [0:63];
  logic        ld_en = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  int n_rd = 0, n_wr = 0, hold_err = 0;
  logic [31:0] last_rd_addr = '0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_ack <= 1'b0;
    if (ld_en) mem[ld_addr] <= ld_data;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin mem[mem_addr[5:0]] <= mem_wdata; n_wr <= n_wr + 1; end
      else begin mem_rdata <= mem[mem_addr[5:0]]; n_rd <= n_rd + 1; last_rd_addr <= mem_addr; end
    end
    if (pend && (!mem_req || mem_addr != pend_addr)) hold_err <= hold_err + 1;
    pend <= mem_req && !mem_ack && !(mem_req && !mem_ack && pend == 1'b0 && 1'b0);
    pend_addr <= mem_addr;
    if (mem_ack) pend <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic logic [1:0] exp_fc(input int vpn, input int len, input logic [31:0] e, input logic [1:0] a);
    bit ok;
    if (vpn >= len) return 2'd1;
    if (e[0] == 1'b0) return 2'd2;
    case (a)
      2'd0: ok = 1'b1;
      2'd1: ok = e[1];
      2'd2: ok = e[2];
      default: ok = 1'b0;
    endcase
    return ok ? 2'd0 : 2'd3;
  endfunction

  function automatic logic [31:0] exp_entry(input logic [31:0] e, input logic [1:0] a);
    return e | 32'h10 | ((a == 2'd1) ? 32'h8 : 32'h0);
  endfunction

  // one full request with every check on its outcome
  task automatic run(input int base, input int len, input int vpn, input logic [11:0] off,
                     input logic [1:0] a, input logic [31:0] e);
    int rd0, wr0, wait_n;
    logic [1:0]  efc;
    logic [31:0] eent, epa;
    bit          got;
    poke(6'(base + vpn), e);
    efc  = exp_fc(vpn, len, e, a);
    eent = (efc == 2'd0) ? exp_entry(e, a) : e;
    epa  = (efc == 2'd0) ? {e[31:12], off} : 32'h0;
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    tbl_base = 32'(base); tbl_len = 21'(len);
    req_vaddr = {20'(vpn), off}; req_acc = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0; wait_n = 0;
    while (!got && wait_n < 50) begin
      if (resp_valid) got = 1'b1;
      else begin @(negedge clk); wait_n++; end
    end
    if (!got) begin chk(1'b0, "R8 watchdog", 0, 1); return; end
    chk(resp_fcode == efc, "R6 fault code", resp_fcode, efc);
    chk(resp_fault == (efc != 2'd0), "R8 fault flag", resp_fault, efc != 2'd0);
    chk(resp_paddr == epa, "R1 physical address", resp_paddr, epa);
    chk(n_rd - rd0 == ((efc == 2'd1) ? 0 : 1), "R3 read count", n_rd - rd0, (efc == 2'd1) ? 0 : 1);
    if (efc != 2'd1) chk(last_rd_addr == 32'(base + vpn), "R2 entry address", last_rd_addr, base + vpn);
    chk(n_wr - wr0 == ((eent != e) ? 1 : 0), "R7 writeback count", n_wr - wr0, (eent != e) ? 1 : 0);
    @(negedge clk);
    chk(!resp_valid && req_ready, "R8 single pulse", {resp_valid, req_ready}, 2'b01);
    chk(mem[6'(base + vpn)] == eent, "R7 stored entry", mem[6'(base + vpn)], eent);
  endtask

  initial begin : wdog
    wait (cycles > 150000);
    chk(1'b0, "R8 global watchdog", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); ld_en = 1'b1; ld_addr = 6'(i); ld_data = 32'hDEAD_0000 | 32'(i);
    end
    @(negedge clk); ld_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0 || req_ready == 1'b1, "R8 reset ready known", req_ready, 1);
    chk(!resp_valid && !mem_req, "R8 reset quiet", {resp_valid, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R8 idle after reset", {req_ready, resp_valid, mem_req}, 3'b100);

    // R1: page 2 in frame 8, RW, clean -> read sets accessed flag
    run(4, 10, 2, 12'hABC, 2'd0, {20'd8, 12'h003});
    // R7: write hits clean entry -> accessed and modified set in one writeback
    run(4, 10, 3, 12'h010, 2'd1, {20'h12345, 12'h003});
    // R7: already marked -> no write
    run(4, 10, 3, 12'h020, 2'd1, {20'h12345, 12'h01B});
    // R3: boundary at len exactly and len-1, and empty table
    run(0, 7, 7, 12'h0, 2'd0, {20'h1, 12'h007});
    run(0, 7, 6, 12'h0, 2'd0, {20'h1, 12'h001});
    run(9, 0, 0, 12'h5, 2'd0, {20'h2, 12'h001});
    // R4 / R6: absent wins over forbidden write
    run(2, 30, 5, 12'h1, 2'd1, {20'h3, 12'h000});
    // R5: read-only entry refuses write and execute; reserved kind faults
    run(2, 30, 6, 12'h1, 2'd1, {20'h3, 12'h001});
    run(2, 30, 6, 12'h1, 2'd2, {20'h3, 12'h001});
    run(2, 30, 7, 12'h1, 2'd3, {20'h3, 12'h007});
    // R5: execute on read+execute entry succeeds
    run(2, 30, 8, 12'hFFF, 2'd2, {20'hFFFFF, 12'h005});

    for (int n = 0; n < 400; n++) begin
      logic [31:0] e;
      e = $urandom;
      e[0] = ($urandom % 4) != 0;
      run(int'($urandom % 16), int'($urandom % 41), int'($urandom % 48),
          12'($urandom), 2'($urandom), e);
    end
    chk(hold_err == 0, "R9 request held until ack", hold_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule